// File: doc/BRIEF.md
# Triplex Approximate-Agreement Voter

This block merges three redundant copies of one measured quantity into a single voted value. It also reports which copies it no longer trusts. The three values enter together with a per-channel valid flag, and one strobe marks the decision point at which all three belong to the same sample set. On each strobed cycle every pair of channels is compared. Two channels count as matching when the magnitude of their difference stays inside a programmable tolerance. The difference is clamped, so values at opposite ends of the range never wrap into a false match.

A channel is marked faulty only when all three channels are valid, the other two match each other, and both of them differ from it. A single disagreeing peer is never enough to condemn a channel. A faulty channel takes no part in the vote. It returns only after it has matched a trusted peer on a fixed number of consecutive samples.

The voted output depends on how many channels take part in the vote:
- Three channels: the output is the median.
- Two channels: the output is their average.
- Fewer than two: the output holds its last value and a no-consensus flag is raised.

In every case the output stays inside the span of the channels that took part, so losing or regaining a channel never jumps the output outside the values the healthy channels agree on.

Top module: `triplex_voter`

## Requirements
- R1: While reset is asserted, `voted` is 0, `no_consensus` is 1 and `ch_fault` is 000.
- R2: Two channels match when the magnitude of their signed difference, clamped to 2^(W-1)-1, is less than or equal to `tol`. Extreme values of opposite sign are therefore never taken as matching through wrap-around.
- R3: On a strobed sample with all three `ch_ok` bits set, a channel whose two peers match each other while neither matches it gets its `ch_fault` bit set (bit 0 = `ch_a`, bit 1 = `ch_b`, bit 2 = `ch_c`). At most one bit is newly set per sample, and none is newly set unless all three channels are valid.
- R4: A channel takes part in the vote when it is valid, not faulty, and not being condemned on that sample. With three taking part, `voted` becomes their median at the strobing edge.
- R5: With exactly two channels taking part, `voted` becomes floor((x+y)/2) of their values.
- R6: With fewer than two channels taking part, `voted` keeps its previous value and `no_consensus` is 1. Otherwise `no_consensus` is 0.
- R7: A faulty channel clears its `ch_fault` bit at the edge of the READMIT-th consecutive strobed sample on which it is valid and matches at least one valid non-faulty peer. A sample that fails this test restarts the count.
- R8: When `sample_en` is low, `voted`, `no_consensus` and `ch_fault` do not change, whatever the other inputs are.
- R9: Whenever two or more channels take part, the new `voted` lies between the smallest and the largest value among the channels taking part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Decision-point strobe; the channel values are a consistent set |
| ch_a | input | W | Channel A value, two's complement |
| ch_b | input | W | Channel B value, two's complement |
| ch_c | input | W | Channel C value, two's complement |
| ch_ok | input | 3 | Per-channel valid flags (bit 0 = A) |
| tol | input | W-1 | Agreement tolerance, unsigned |
| voted | output | W | Voted value, registered |
| no_consensus | output | 1 | Fewer than two channels took part in the last vote |
| ch_fault | output | 3 | Per-channel faulty/excluded flags (bit 0 = A) |

## Verification
The assertions take for granted that the three channel values and their valid flags are stable and mutually consistent on the cycle `sample_en` is high. They also take for granted that `tol` does not change in the middle of a sample. The bench drives every input at the falling edge and holds it through the next rising edge. It changes `tol` only between samples, and on idle cycles it drives random values that the block must ignore. The sweeps cover every triple of a 4-bit configuration under several tolerances, then every valid-flag pattern over a smaller value set. The bench's own model carries the faulty and readmission state from sample to sample.

// File: rtl/tmv_pkg.sv
package tmv_pkg;

  localparam int NCH = 3;

  typedef enum logic [1:0] {
    SEL_HOLD   = 2'd0,
    SEL_PAIR   = 2'd1,
    SEL_MEDIAN = 2'd2
  } sel_mode_e;

endpackage

// File: rtl/tmv_agree.sv
module tmv_agree #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  logic        [W-2:0] tol,
  output logic                match
);

  localparam logic [W:0] LIM = {2'b00, {(W-1){1'b1}}};

  logic signed [W:0] diff;
  logic        [W:0] absd;
  logic        [W-2:0] mag;

  always_comb begin
    diff = {x[W-1], x} - {y[W-1], y};
    absd = diff[W] ? (~diff + 1'b1) : diff;
    if (absd > LIM) begin
      mag = LIM[W-2:0];
    end else begin
      mag = absd[W-2:0];
    end
    match = (mag <= tol);
  end

endmodule

// File: rtl/tmv_health.sv
module tmv_health #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic condemn,
  input  logic mate_ok,
  output logic excl
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          excl_q, excl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    excl_d = excl_q;
    cnt_d  = cnt_q;
    if (en) begin
      if (condemn) begin
        excl_d = 1'b1;
        cnt_d  = '0;
      end else if (excl_q) begin
        if (mate_ok) begin
          if (cnt_q == LAST) begin
            excl_d = 1'b0;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end else begin
          cnt_d = '0;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      excl_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      excl_q <= excl_d;
      cnt_q  <= cnt_d;
    end
  end

  assign excl = excl_q;

endmodule

// File: rtl/tmv_select.sv
module tmv_select
  import tmv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] val_a,
  input  logic signed [W-1:0] val_b,
  input  logic signed [W-1:0] val_c,
  input  logic        [2:0]   part,
  input  logic signed [W-1:0] held,
  output logic signed [W-1:0] pick,
  output logic                lack
);

  sel_mode_e          mode;
  logic signed [W-1:0] med;
  logic signed [W-1:0] pa, pb;
  logic signed [W:0]   psum;

  always_comb begin
    case ($countones(part))
      3:       mode = SEL_MEDIAN;
      2:       mode = SEL_PAIR;
      default: mode = SEL_HOLD;
    endcase
  end

  always_comb begin
    if (val_a >= val_b) begin
      if (val_b >= val_c)      med = val_b;
      else if (val_a >= val_c) med = val_c;
      else                     med = val_a;
    end else begin
      if (val_a >= val_c)      med = val_a;
      else if (val_b >= val_c) med = val_c;
      else                     med = val_b;
    end
  end

  always_comb begin
    case (part)
      3'b011: begin pa = val_a; pb = val_b; end
      3'b101: begin pa = val_a; pb = val_c; end
      default: begin pa = val_b; pb = val_c; end
    endcase
    psum = {pa[W-1], pa} + {pb[W-1], pb};
  end

  always_comb begin
    case (mode)
      SEL_MEDIAN: pick = med;
      SEL_PAIR:   pick = psum[W:1];
      default:    pick = held;
    endcase
    lack = (mode == SEL_HOLD);
  end

endmodule

// File: rtl/triplex_voter.sv
module triplex_voter
  import tmv_pkg::*;
#(
  parameter int W       = 16,
  parameter int READMIT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic signed [W-1:0] ch_a,
  input  logic signed [W-1:0] ch_b,
  input  logic signed [W-1:0] ch_c,
  input  logic        [2:0]   ch_ok,
  input  logic        [W-2:0] tol,
  output logic signed [W-1:0] voted,
  output logic                no_consensus,
  output logic        [2:0]   ch_fault
);

  logic signed [W-1:0] chv [NCH];
  logic [NCH-1:0] agr;
  logic [NCH-1:0] excl;
  logic [NCH-1:0] condemn;
  logic [NCH-1:0] mate_ok;
  logic [NCH-1:0] active;
  logic [NCH-1:0] part;

  logic signed [W-1:0] pick;
  logic                lack;
  logic signed [W-1:0] voted_q, voted_d;
  logic                nocon_q, nocon_d;

  assign chv[0] = ch_a;
  assign chv[1] = ch_b;
  assign chv[2] = ch_c;

  // pair p compares channel p with channel p+1 (mod 3)
  for (genvar p = 0; p < NCH; p++) begin : g_pair
    tmv_agree #(.W(W)) u_pair (
      .x     (chv[p]),
      .y     (chv[(p + 1) % NCH]),
      .tol   (tol),
      .match (agr[p])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam int J = (i + 1) % NCH;
    localparam int K = (i + 2) % NCH;

    // agr[J] is the pair of the two peers; agr[i], agr[K] involve channel i
    assign condemn[i] = (&ch_ok) & agr[J] & ~agr[i] & ~agr[K];
    assign mate_ok[i] = ch_ok[i] & ((agr[i] & active[J]) | (agr[K] & active[K]));

    tmv_health #(.N(READMIT)) u_health (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (sample_en),
      .condemn (condemn[i]),
      .mate_ok (mate_ok[i]),
      .excl    (excl[i])
    );
  end

  assign active = ch_ok & ~excl;
  assign part   = active & ~condemn;

  tmv_select #(.W(W)) u_select (
    .val_a (ch_a),
    .val_b (ch_b),
    .val_c (ch_c),
    .part  (part),
    .held  (voted_q),
    .pick  (pick),
    .lack  (lack)
  );

  always_comb begin
    voted_d = voted_q;
    nocon_d = nocon_q;
    if (sample_en) begin
      voted_d = pick;
      nocon_d = lack;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      voted_q <= '0;
      nocon_q <= 1'b1;
    end else begin
      voted_q <= voted_d;
      nocon_q <= nocon_d;
    end
  end

  assign voted        = voted_q;
  assign no_consensus = nocon_q;
  assign ch_fault     = excl;

endmodule

// File: rtl/triplex_voter_chk.sv
module triplex_voter_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_en,
  input logic signed [W-1:0] ch_a,
  input logic signed [W-1:0] ch_b,
  input logic signed [W-1:0] ch_c,
  input logic        [2:0]   ch_ok,
  input logic        [2:0]   part,
  input logic signed [W-1:0] voted,
  input logic                no_consensus,
  input logic        [2:0]   ch_fault
);

  logic signed [W-1:0] lo, hi;
  logic signed [W-1:0] v [3];

  assign v[0] = ch_a;
  assign v[1] = ch_b;
  assign v[2] = ch_c;

  always_comb begin
    lo = {1'b0, {(W-1){1'b1}}};
    hi = {1'b1, {(W-1){1'b0}}};
    for (int i = 0; i < 3; i++) begin
      if (part[i]) begin
        if (v[i] < lo) lo = v[i];
        if (v[i] > hi) hi = v[i];
      end
    end
  end

  assert_one_condemn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_fault & ~$past(ch_fault)));

  assert_valid_condemn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ch_ok != 3'b111) |=> ((ch_fault & ~$past(ch_fault)) == 3'b000));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(voted) && $stable(no_consensus) && $stable(ch_fault)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_consensus |-> $stable(voted));

  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && $countones(part) < 2) |=> no_consensus);

  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && $countones(part) >= 2) |=>
      (!no_consensus && voted >= $past(lo) && voted <= $past(hi)));

endmodule

bind triplex_voter triplex_voter_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_en    (sample_en),
  .ch_a         (ch_a),
  .ch_b         (ch_b),
  .ch_c         (ch_c),
  .ch_ok        (ch_ok),
  .part         (part),
  .voted        (voted),
  .no_consensus (no_consensus),
  .ch_fault     (ch_fault)
);

// File: tb/triplex_voter_bench.sv
`timescale 1ns/1ps
module triplex_voter_bench;

  localparam int W   = 4;
  localparam int RN  = 3;
  localparam int LIM = (1 << (W - 1)) - 1;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                sample_en;
  logic signed [W-1:0] ch_a, ch_b, ch_c;
  logic        [2:0]   ch_ok;
  logic        [W-2:0] tol;
  logic signed [W-1:0] voted;
  logic                no_consensus;
  logic        [2:0]   ch_fault;

  always #2 clk = ~clk;

  triplex_voter #(.W(W), .READMIT(RN)) u_triplex_voter (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c), .ch_ok(ch_ok), .tol(tol),
    .voted(voted), .no_consensus(no_consensus), .ch_fault(ch_fault)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit m_excl [3];
  int m_cnt  [3];
  int m_out;
  bit m_nc;

  function automatic bit agree_m(int x, int y, int t);
    int d;
    d = x - y;
    if (d < 0) d = -d;
    if (d > LIM) d = LIM;
    return d <= t;
  endfunction

  function automatic int med3(int a, int b, int c);
    int lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (c <= lo) return lo;
    if (c >= hi) return hi;
    return c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fault_vec();
    return int'(m_excl[0]) + 2 * int'(m_excl[1]) + 4 * int'(m_excl[2]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_excl[i] = 1'b0;
      m_cnt[i]  = 0;
    end
    m_out = 0;
    m_nc  = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sample_en = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset voted", int'(voted), 0);
    chk("R1 reset no_consensus", int'(no_consensus), 1);
    chk("R1 reset ch_fault", int'(ch_fault), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(int xa, int xb, int xc, logic [2:0] ok, int t);
    int  v [3];
    bit  ag [3];
    bit  cond [3], act [3], mate [3], prt [3];
    int  np, lo, hi, s;
    v[0] = xa; v[1] = xb; v[2] = xc;
    ch_a = W'(xa); ch_b = W'(xb); ch_c = W'(xc);
    ch_ok = ok; tol = (W-1)'(t); sample_en = 1'b1;
    for (int p = 0; p < 3; p++) ag[p] = agree_m(v[p], v[(p + 1) % 3], t);
    for (int i = 0; i < 3; i++) begin
      cond[i] = (ok == 3'b111) && ag[(i + 1) % 3] && !ag[i] && !ag[(i + 2) % 3];
      act[i]  = ok[i] && !m_excl[i];
    end
    np = 0; s = 0; lo = 100; hi = -100;
    for (int i = 0; i < 3; i++) begin
      mate[i] = ok[i] && ((ag[i] && act[(i + 1) % 3]) || (ag[(i + 2) % 3] && act[(i + 2) % 3]));
      prt[i]  = act[i] && !cond[i];
      if (prt[i]) begin
        np++; s += v[i];
        if (v[i] < lo) lo = v[i];
        if (v[i] > hi) hi = v[i];
      end
    end
    if (np == 3) begin
      m_out = med3(v[0], v[1], v[2]); m_nc = 1'b0;
    end else if (np == 2) begin
      m_out = s >>> 1; m_nc = 1'b0;
    end else begin
      m_nc = 1'b1;
    end
    for (int i = 0; i < 3; i++) begin
      if (cond[i]) begin
        m_excl[i] = 1'b1; m_cnt[i] = 0;
      end else if (m_excl[i]) begin
        if (mate[i]) begin
          if (m_cnt[i] == RN - 1) begin m_excl[i] = 1'b0; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end else m_cnt[i] = 0;
      end else m_cnt[i] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    if (np == 3)      chk("R4 median", int'(voted), m_out);
    else if (np == 2) chk("R5 average", int'(voted), m_out);
    else              chk("R6 hold", int'(voted), m_out);
    chk("R6 no_consensus", int'(no_consensus), int'(m_nc));
    chk("R3/R7 ch_fault", int'(ch_fault), fault_vec());
    if (np >= 2)
      chk("R9 within range", int'(int'(voted) >= lo && int'(voted) <= hi), 1);
  endtask

  task automatic idle();
    sample_en = 1'b0;
    ch_a = W'($urandom); ch_b = W'($urandom); ch_c = W'($urandom);
    ch_ok = 3'($urandom);
    @(posedge clk);
    @(negedge clk);
    chk("R8 idle voted", int'(voted), m_out);
    chk("R8 idle no_consensus", int'(no_consensus), int'(m_nc));
    chk("R8 idle ch_fault", int'(ch_fault), fault_vec());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int tols [3];
    int vs [7];
    int k;
    tols = '{0, 2, 7};
    vs   = '{-8, -5, -1, 0, 1, 3, 7};
    ch_a = '0; ch_b = '0; ch_c = '0; ch_ok = '0; tol = '0;
    do_reset();

    k = 0;
    for (int ti = 0; ti < 3; ti++)
      for (int a = -8; a < 8; a++)
        for (int b = -8; b < 8; b++)
          for (int c = -8; c < 8; c++) begin
            step(a, b, c, 3'b111, tols[ti]);
            k++;
            if (k % 9 == 0) idle();
          end

    for (int t = 1; t < 4; t += 2)
      for (int okv = 0; okv < 8; okv++)
        for (int a = 0; a < 7; a++)
          for (int b = 0; b < 7; b++)
            for (int c = 0; c < 7; c++)
              step(vs[a], vs[b], vs[c], 3'(okv), t);

    // R7: readmission needs RN consecutive matching samples
    do_reset();
    step(0, 0, 7, 3'b111, 1);
    chk("R3 condemn channel c", int'(ch_fault), 4);
    step(0, 0, 0, 3'b111, 1);
    step(0, 0, 1, 3'b111, 1);
    step(0, 0, 5, 3'b111, 1);
    chk("R7 streak broken, still faulty", int'(ch_fault), 4);
    step(0, 0, 0, 3'b111, 1);
    step(0, 0, 0, 3'b011, 1);
    chk("R7 invalid sample restarts count", int'(ch_fault), 4);
    step(0, 0, 1, 3'b111, 1);
    step(1, 0, 0, 3'b111, 1);
    chk("R7 not yet readmitted", int'(ch_fault), 4);
    step(0, 0, 0, 3'b111, 1);
    chk("R7 readmitted after RN samples", int'(ch_fault), 0);

    // R2: opposite extremes must not match through wrap-around
    do_reset();
    step(7, -8, -8, 3'b111, 6);
    chk("R2 clamped difference condemns a", int'(ch_fault), 1);
    chk("R2 pair average of b and c", int'(voted), -8);
    step(7, -8, -8, 3'b111, 7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule